// File: doc/BRIEF.md
# Selectable-Period Supervisory Watchdog

This block supervises firmware for a power-management companion device. Firmware picks one of four timeout windows with a 2-bit selector. It keeps the system alive by pulsing a service strobe, which stands for a correct write to the timer register. Time is measured in ticks of a 1 ms strobe. If the number of ticks since the last service reaches the active window, the block does three things: it pulls an active-low error flag low, it raises a reset request for a fixed number of ticks, and it sets a sticky status bit that records a watchdog reset.

A mode input tells the block which operating state the device is in. In the start-up request state a fixed long window applies, whatever the selector says. In the low-power stop state an enable bit decides whether supervision continues. When that bit is clear the count is held at zero. The status bit clears when firmware reads it.

Top module: `wdt_supervisor`

## Requirements
- R1: After reset `wdog_err_n` is 1, `rst_req` is 0, `wd_rst_flag` is 0, and the latched window selection is 3 (the longest window).
- R2: Selector values 0, 1, 2 and 3 give windows of P0, P1, P2 and P3 ticks (defaults 10, 45, 100, 350). With no service, exactly that many ticks after the last service write trigger a timeout. One tick fewer does not.
- R3: A timeout drives `wdog_err_n` low and `rst_req` high, both in the clock cycle that follows the terminal tick.
- R4: Once low, `wdog_err_n` stays low through and after the reset pulse. Only a service write accepted outside the pulse returns it to 1.
- R5: `rst_req` stays high for exactly RST_TICKS ticks (default 3). The tick count restarts from zero when the pulse ends, so a further timeout needs a full window.
- R6: `per_sel` is sampled only on an accepted service write. A change on `per_sel` without a service write does not alter the window.
- R7: In mode 1 (start-up request) the window is BOOT_TICKS (default 350) for every selector value.
- R8: In mode 2 (stop) with `stop_run_en` = 0, the tick count is held at zero and no timeout occurs. With `stop_run_en` = 1, counting proceeds with the selected window. Modes 0 (normal) and 3 (standby) always count.
- R9: `wd_rst_flag` is set by a timeout and cleared by a `stat_rd` strobe. If both happen in the same cycle, the flag ends up set.
- R10: A service write during the reset pulse is ignored: it neither clears the error flag nor latches a new selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe, once per millisecond |
| per_sel | input | 2 | Window selector, sampled on service |
| svc_wr | input | 1 | Service strobe (timer register written correctly) |
| mode | input | 2 | 0 normal, 1 start-up request, 2 stop, 3 standby |
| stop_run_en | input | 1 | Keep supervising while in stop mode |
| stat_rd | input | 1 | Status read strobe, clears the reset record |
| wdog_err_n | output | 1 | Active-low watchdog error flag |
| rst_req | output | 1 | System reset request pulse |
| wd_rst_flag | output | 1 | Sticky record of a watchdog reset |

## Verification
Each window is probed one tick short of its limit and again at its limit. An off-by-one compare would fire a tick early or late, and a wrong mux entry would fire at the wrong window altogether. Stop mode with supervision disabled is entered partway through a window and then left again. A design that froze the count instead of clearing it would time out early after resuming. A service write with a new selector is issued during the reset pulse. A design that accepted it would clear the error flag and then run the following window at 350 ticks instead of 10. A status read is made in the same cycle as a timeout, which catches a design that lets the clear win.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'd0,
        MODE_BOOT = 2'd1,
        MODE_HALT = 2'd2,
        MODE_IDLE = 2'd3
    } wd_mode_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wdt_limit_mux.sv
module wdt_limit_mux #(
    parameter int unsigned W    = 9,
    parameter int unsigned P0   = 10,
    parameter int unsigned P1   = 45,
    parameter int unsigned P2   = 100,
    parameter int unsigned P3   = 350,
    parameter int unsigned BOOT = 350
) (
    input  logic [1:0]   sel,
    input  logic         boot,
    output logic [W-1:0] limit
);
    localparam int unsigned NSEL = 4;
    localparam int unsigned PER [NSEL] = '{P0, P1, P2, P3};

    logic [W-1:0] per_tab [NSEL];

    for (genvar g = 0; g < NSEL; g++) begin : g_tab
        assign per_tab[g] = W'(PER[g]);
    end

    assign limit = boot ? W'(BOOT) : per_tab[sel];

endmodule

// File: rtl/wdt_rst_stretch.sv
module wdt_rst_stretch #(
    parameter int unsigned LEN = 3,
    parameter int unsigned W   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic fire,
    output logic active
);
    logic [W-1:0] left_d, left_q;

    always_comb begin
        left_d = left_q;
        if (fire) begin
            left_d = W'(LEN);
        end else if (tick && (left_q != '0)) begin
            left_d = left_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) left_q <= '0;
        else        left_q <= left_d;
    end

    assign active = (left_q != '0);

endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor
    import wdt_pkg::*;
#(
    parameter int unsigned P0         = 10,
    parameter int unsigned P1         = 45,
    parameter int unsigned P2         = 100,
    parameter int unsigned P3         = 350,
    parameter int unsigned BOOT_TICKS = 350,
    parameter int unsigned RST_TICKS  = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] per_sel,
    input  logic       svc_wr,
    input  logic [1:0] mode,
    input  logic       stop_run_en,
    input  logic       stat_rd,
    output logic       wdog_err_n,
    output logic       rst_req,
    output logic       wd_rst_flag
);
    localparam int unsigned MAX_T = max2(max2(max2(P0, P1), max2(P2, P3)), BOOT_TICKS);
    localparam int unsigned CNT_W = $clog2(MAX_T + 1);
    localparam int unsigned RST_W = $clog2(RST_TICKS + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [1:0]       sel;
        logic             err_n;
        logic             flag;
    } wd_state_t;

    wd_state_t        st_d, st_q;
    logic [CNT_W-1:0] limit;
    logic             fire;
    logic             pulsing;
    logic             counting;
    logic             boot_mode;

    assign boot_mode = (wd_mode_e'(mode) == MODE_BOOT);
    assign counting  = !((wd_mode_e'(mode) == MODE_HALT) && !stop_run_en);

    wdt_limit_mux #(
        .W(CNT_W), .P0(P0), .P1(P1), .P2(P2), .P3(P3), .BOOT(BOOT_TICKS)
    ) u_limit (
        .sel  (st_q.sel),
        .boot (boot_mode),
        .limit(limit)
    );

    wdt_rst_stretch #(
        .LEN(RST_TICKS), .W(RST_W)
    ) u_stretch (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .fire  (fire),
        .active(pulsing)
    );

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        if (stat_rd) st_d.flag = 1'b0;
        if (!counting) st_d.cnt = '0;
        if (pulsing) begin
            st_d.cnt = '0;
        end else if (svc_wr) begin
            st_d.cnt   = '0;
            st_d.sel   = per_sel;
            st_d.err_n = 1'b1;
        end else if (counting && tick) begin
            if (({1'b0, st_q.cnt} + 1'b1) >= {1'b0, limit}) begin
                fire       = 1'b1;
                st_d.cnt   = '0;
                st_d.err_n = 1'b0;
                st_d.flag  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.sel   <= 2'd3;
            st_q.err_n <= 1'b1;
            st_q.flag  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wdog_err_n  = st_q.err_n;
    assign rst_req     = pulsing;
    assign wd_rst_flag = st_q.flag;

endmodule

// File: rtl/wdt_supervisor_chk.sv
module wdt_supervisor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       svc_wr,
    input logic [1:0] mode,
    input logic       stop_run_en,
    input logic       stat_rd,
    input logic       wdog_err_n,
    input logic       rst_req,
    input logic       wd_rst_flag
);
    // R3
    err_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> !wdog_err_n);

    // R3
    err_fall_only_on_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdog_err_n) |-> $rose(rst_req));

    // R4
    err_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wdog_err_n && !(svc_wr && !rst_req)) |=> !wdog_err_n);

    // R4
    svc_clears_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_wr && !rst_req) |=> (wdog_err_n && !rst_req));

    // R5
    pulse_ends_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req) |-> $past(tick));

    // R8
    halt_no_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && !stop_run_en && !rst_req) |=> !rst_req);

    // R9
    flag_on_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> wd_rst_flag);

    // R9
    flag_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_rst_flag) |-> $rose(rst_req));

    // R9
    flag_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_rst_flag) |-> $past(stat_rd));
endmodule

bind wdt_supervisor wdt_supervisor_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .svc_wr     (svc_wr),
    .mode       (mode),
    .stop_run_en(stop_run_en),
    .stat_rd    (stat_rd),
    .wdog_err_n (wdog_err_n),
    .rst_req    (rst_req),
    .wd_rst_flag(wd_rst_flag)
);

// File: tb/tb_wdt_supervisor.sv
module tb_wdt_supervisor;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] per_sel = 2'd0;
    logic       svc_wr = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       stop_run_en = 1'b0;
    logic       stat_rd = 1'b0;
    logic       wdog_err_n, rst_req, wd_rst_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam int RST_LEN = 3;

    // {mode[15:14], sel[13:12], stop_run_en[11], window[10:0]}
    localparam logic [15:0] VEC [6] = '{
        {2'd0, 2'd0, 1'b0, 11'd10},
        {2'd0, 2'd1, 1'b0, 11'd45},
        {2'd3, 2'd2, 1'b0, 11'd100},
        {2'd0, 2'd3, 1'b0, 11'd350},
        {2'd1, 2'd0, 1'b0, 11'd350},
        {2'd2, 2'd1, 1'b1, 11'd45}
    };

    always #2.5 clk = ~clk;

    wdt_supervisor dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .per_sel(per_sel),
        .svc_wr(svc_wr), .mode(mode), .stop_run_en(stop_run_en),
        .stat_rd(stat_rd), .wdog_err_n(wdog_err_n), .rst_req(rst_req),
        .wd_rst_flag(wd_rst_flag)
    );

    task automatic check(input string req, input string what, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic service(input logic [1:0] s);
        @(negedge clk) begin svc_wr = 1'b1; per_sel = s; end
        @(negedge clk) svc_wr = 1'b0;
    endtask

    task automatic read_status();
        @(negedge clk) stat_rd = 1'b1;
        @(negedge clk) stat_rd = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "err_n after reset", wdog_err_n, 1'b1);
        check("R1", "rst_req after reset", rst_req, 1'b0);
        check("R1", "flag after reset", wd_rst_flag, 1'b0);
        // R1: default window is 350 ticks
        ticks(349);
        check("R1", "no timeout at 349 default", rst_req, 1'b0);
        ticks(1);
        check("R1", "timeout at 350 default", rst_req, 1'b1);
        ticks(RST_LEN);
        read_status();

        // Table walk: R2 R3 R4 R5 R7 R8 R9
        for (int v = 0; v < 6; v++) begin
            int lim;
            lim = int'(VEC[v][10:0]);
            mode = VEC[v][15:14];
            stop_run_en = VEC[v][11];
            service(VEC[v][13:12]);
            check("R4", "err_n after service", wdog_err_n, 1'b1);
            ticks(lim - 1);
            check("R2", "no timeout one tick short", rst_req, 1'b0);
            check("R2", "err_n one tick short", wdog_err_n, 1'b1);
            ticks(1);
            check("R3", "rst_req at window", rst_req, 1'b1);
            check("R3", "err_n low at window", wdog_err_n, 1'b0);
            check("R9", "flag set on timeout", wd_rst_flag, 1'b1);
            ticks(RST_LEN - 1);
            check("R5", "pulse still high", rst_req, 1'b1);
            ticks(1);
            check("R5", "pulse ended", rst_req, 1'b0);
            check("R4", "err_n held after pulse", wdog_err_n, 1'b0);
            read_status();
            check("R9", "flag cleared by read", wd_rst_flag, 1'b0);
        end

        // R6: selector change without service has no effect
        mode = 2'd0; stop_run_en = 1'b0;
        service(2'd0);
        @(negedge clk) per_sel = 2'd3;
        ticks(9);
        check("R6", "no timeout at 9", rst_req, 1'b0);
        ticks(1);
        check("R6", "timeout at 10 despite sel change", rst_req, 1'b1);
        // R10: service during pulse ignored
        service(2'd3);
        check("R10", "err_n stays low after svc in pulse", wdog_err_n, 1'b0);
        ticks(RST_LEN);
        check("R10", "err_n low after pulse", wdog_err_n, 1'b0);
        // R5: count restarts after pulse; window still 10 (R10)
        ticks(9);
        check("R5", "no re-timeout at 9 after pulse", rst_req, 1'b0);
        ticks(1);
        check("R10", "re-timeout at 10, sel not latched", rst_req, 1'b1);
        ticks(RST_LEN);
        read_status();

        // R8: stop with supervision disabled clears the count
        service(2'd0);
        ticks(5);
        mode = 2'd2; stop_run_en = 1'b0;
        ticks(30);
        check("R8", "no timeout in disabled stop", rst_req, 1'b0);
        check("R8", "err_n high in disabled stop", wdog_err_n, 1'b1);
        mode = 2'd0;
        ticks(9);
        check("R8", "count restarted from zero", rst_req, 1'b0);
        ticks(1);
        check("R8", "full window after stop", rst_req, 1'b1);
        ticks(RST_LEN);
        read_status();

        // R9: read and timeout in the same cycle, set wins
        service(2'd0);
        ticks(9);
        @(negedge clk) begin tick = 1'b1; stat_rd = 1'b1; end
        @(negedge clk) begin tick = 1'b0; stat_rd = 1'b0; end
        check("R9", "set wins over read", wd_rst_flag, 1'b1);
        read_status();
        check("R9", "later read clears", wd_rst_flag, 1'b0);
        ticks(RST_LEN);
        service(2'd0);
        check("R4", "service after pulse clears err", wdog_err_n, 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule